// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between a clocked host and a 512K x 16 asynchronous static RAM. The host issues one word request at a time. A request is a single-cycle strobe with a write flag, a 19-bit word address, 16 bits of write data and two byte-lane enables. The controller turns it into a pin-level memory cycle. It drives the address, a pair of chip enables of opposite polarity, active-low write and output enables, and active-low lower and upper byte selects. It also steers a data bus that is split into output value, output enable and input value, so the bidirectional pad can be placed outside the block.

Every interval is a whole number of clock cycles. Each interval is computed at elaboration from a nanosecond minimum and the clock-period parameter. The rule is the ceiling of the quotient, and never less than one cycle. A read keeps the memory selected with output enable low for the whole access phase and captures the data on the last cycle of that phase. A write keeps output enable high throughout. It waits until the memory has had time to release the bus, pulses write enable low while driving the data, then holds the data for a recovery phase. A one-cycle done pulse closes every request.

Top module: `sram_ctrl`

## Requirements
- R1: Out of reset, and whenever no request is in progress, the memory is deselected: `mem_sel_n`=1, `mem_sel`=0, `mem_we_n`=1, `mem_oe_n`=1, `mem_lo_n`=1, `mem_hi_n`=1, `mem_dat_oe`=0. After reset `done`=0 and `rd_data`=0.
- R2: A read holds the memory selected, with `mem_we_n`=1 and `mem_oe_n`=0, for exactly RD_CYC = c(max(T_RC_NS, T_AA_NS)) consecutive cycles. Here c(t) = max(1, ceil(t / CLK_NS)). During that time `mem_lo_n` = !`req_be[0]` (bits 7..0) and `mem_hi_n` = !`req_be[1]` (bits 15..8).
- R3: `rd_data` takes the memory data sampled on the final cycle of the read access phase. Byte lanes whose enable was 0 read as zero.
- R4: During a write, `mem_oe_n` stays 1 and `mem_we_n` is 0 for exactly WP_CYC = max(c(T_WP_NS), c(T_AW_NS), c(T_DW_NS)) consecutive cycles. `mem_oe_n` and `mem_we_n` are never low together.
- R5: `mem_we_n` is low only while `mem_sel_n`=0 and `mem_sel`=1. `mem_addr` never changes while `mem_we_n` is low.
- R6: `mem_dat_oe` is 1 only while `mem_oe_n` has been high for at least OHZ_CYC = c(T_OHZ_NS) completed cycles.
- R7: A write drives the request data while `mem_we_n` is low and during the REC_CYC recovery cycles after it. REC_CYC = max(1, c(T_WC_NS) − WP_CYC − 1). Only the byte lanes selected by `req_be` change in the memory.
- R8: `done` is high for exactly one cycle per accepted request. A read has `done` RD_CYC cycles after the accepting edge. A write has `done` S + WP_CYC + REC_CYC cycles after it. S = max(1, OHZ_CYC + 1 − g), where g is the number of cycles `mem_oe_n` had been high when the request was driven.
- R9: A request strobe that arrives while a cycle is in progress is ignored. It produces no done pulse and no memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Request strobe, taken only when idle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 = bits 7..0, bit 1 = bits 15..8 |
| rd_data | output | 16 | Captured read data |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 19 | Memory address |
| mem_sel_n | output | 1 | Active-low chip enable |
| mem_sel | output | 1 | Active-high chip enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_lo_n | output | 1 | Active-low lower byte select |
| mem_hi_n | output | 1 | Active-low upper byte select |
| mem_dat_o | output | 16 | Data to drive onto the bus |
| mem_dat_oe | output | 1 | Bus driver enable |
| mem_dat_i | input | 16 | Data sampled from the bus |

## Verification
The bench builds the block with its defaults: a 10 ns clock and the fast-grade minimums. This gives a six-cycle read, a five-cycle write pulse set by the address-valid bound rather than the pulse width, one recovery cycle and a three-cycle bus release. Those defaults make the release wait visible: a write issued in the cycle right after a read must spend three setup cycles, while a rested write needs only one. Single-lane writes and reads expose lane masking, and the top and bottom addresses are part of the random pool.

// File: rtl/sram_ctrl.sv
module sram_ctrl #(
  parameter int ADDR_W   = 19,
  parameter int CLK_NS   = 10,
  parameter int T_RC_NS  = 55,
  parameter int T_AA_NS  = 55,
  parameter int T_WC_NS  = 55,
  parameter int T_WP_NS  = 35,
  parameter int T_AW_NS  = 45,
  parameter int T_DW_NS  = 25,
  parameter int T_OHZ_NS = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  input  logic [1:0]        req_be,
  output logic [15:0]       rd_data,
  output logic              done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_sel_n,
  output logic              mem_sel,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              mem_lo_n,
  output logic              mem_hi_n,
  output logic [15:0]       mem_dat_o,
  output logic              mem_dat_oe,
  input  logic [15:0]       mem_dat_i
);

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RD_CYC  = cyc(mx(T_RC_NS, T_AA_NS));
  localparam int WP_CYC  = mx(cyc(T_WP_NS), mx(cyc(T_AW_NS), cyc(T_DW_NS)));
  localparam int REC_CYC = mx(1, cyc(T_WC_NS) - WP_CYC - 1);
  localparam int OHZ_CYC = cyc(T_OHZ_NS);
  localparam int MAXC    = mx(mx(RD_CYC, WP_CYC), mx(REC_CYC, OHZ_CYC));
  localparam int CNT_W   = $clog2(MAXC + 1);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_WSET, S_WP, S_WREC} state_t;

  state_t            st;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  rel;
  logic [ADDR_W-1:0] a_q;
  logic [15:0]       d_q;
  logic [1:0]        be_q;
  logic              busy;
  logic              released;

  assign busy     = (st != S_IDLE);
  assign released = (rel >= CNT_W'(OHZ_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      rel     <= CNT_W'(OHZ_CYC);
      a_q     <= '0;
      d_q     <= '0;
      be_q    <= '0;
      rd_data <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st == S_RD)     rel <= '0;
      else if (!released) rel <= rel + 1'b1;
      case (st)
        S_IDLE: if (req) begin
          a_q  <= req_addr;
          d_q  <= req_wdata;
          be_q <= req_be;
          if (req_wr) begin
            st <= S_WSET;
          end else begin
            st  <= S_RD;
            cnt <= CNT_W'(RD_CYC - 1);
          end
        end
        S_RD: if (cnt == '0) begin
          rd_data <= mem_dat_i & {{8{be_q[1]}}, {8{be_q[0]}}};
          done    <= 1'b1;
          st      <= S_IDLE;
        end else begin
          cnt <= cnt - 1'b1;
        end
        S_WSET: if (released) begin
          st  <= S_WP;
          cnt <= CNT_W'(WP_CYC - 1);
        end
        S_WP: if (cnt == '0) begin
          st  <= S_WREC;
          cnt <= CNT_W'(REC_CYC - 1);
        end else begin
          cnt <= cnt - 1'b1;
        end
        S_WREC: if (cnt == '0) begin
          done <= 1'b1;
          st   <= S_IDLE;
        end else begin
          cnt <= cnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_addr   = a_q;
  assign mem_sel_n  = !busy;
  assign mem_sel    = busy;
  assign mem_we_n   = (st != S_WP);
  assign mem_oe_n   = (st != S_RD);
  assign mem_lo_n   = !(busy && be_q[0]);
  assign mem_hi_n   = !(busy && be_q[1]);
  assign mem_dat_o  = d_q;
  assign mem_dat_oe = (st == S_WP) || (st == S_WREC);

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int ADDR_W   = 19,
  parameter int CLK_NS   = 10,
  parameter int T_OHZ_NS = 25
) (
  input logic              clk,
  input logic              rst_n,
  input logic              done,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_sel_n,
  input logic              mem_sel,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_dat_oe
);

  localparam int OHZ_C = ((T_OHZ_NS + CLK_NS - 1) / CLK_NS < 1) ? 1 : (T_OHZ_NS + CLK_NS - 1) / CLK_NS;

  int unsigned hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           hi_run <= 32'd1000;
    else if (!mem_oe_n)   hi_run <= 0;
    else if (hi_run < 32'd1000) hi_run <= hi_run + 1;
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    mem_sel_n |-> (mem_we_n && mem_oe_n && !mem_dat_oe));

  a_r4_oe_we_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);

  a_r5_we_selected: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_sel_n && mem_sel));

  a_r5_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && !$past(mem_we_n)) |-> $stable(mem_addr));

  a_r6_drive_released: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dat_oe |-> (mem_oe_n && hi_run >= OHZ_C));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind sram_ctrl sram_ctrl_chk #(.ADDR_W(ADDR_W), .CLK_NS(CLK_NS), .T_OHZ_NS(T_OHZ_NS)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .mem_addr(mem_addr),
  .mem_sel_n(mem_sel_n), .mem_sel(mem_sel), .mem_we_n(mem_we_n),
  .mem_oe_n(mem_oe_n), .mem_dat_oe(mem_dat_oe)
);

// File: tb/tb_sram_ctrl.sv
`timescale 1ns/1ps
module tb_sram_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int T_RC = 55, T_AA = 55, T_WC = 55, T_WP = 35, T_AW = 45, T_DW = 25, T_OHZ = 25;

  function automatic int c(input int ns);
    int v;
    v = (ns + CLK_PERIOD - 1) / CLK_PERIOD;
    return (v < 1) ? 1 : v;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RD_CYC  = c(mx(T_RC, T_AA));
  localparam int WP_CYC  = mx(c(T_WP), mx(c(T_AW), c(T_DW)));
  localparam int REC_CYC = mx(1, c(T_WC) - WP_CYC - 1);
  localparam int OHZ_CYC = c(T_OHZ);

  logic        clk = 0, rst_n = 0;
  logic        req = 0, req_wr = 0;
  logic [18:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic [15:0] rd_data, mem_dat_o, mem_dat_i;
  logic        done, mem_sel_n, mem_sel, mem_we_n, mem_oe_n, mem_lo_n, mem_hi_n, mem_dat_oe;
  logic [18:0] mem_addr;

  int checks = 0, errors = 0, cycles = 0;
  bit finished = 0;

  logic [15:0] mem_m [logic [18:0]];
  logic [15:0] sh_m  [logic [18:0]];

  int oe_run = 1000, we_run = 0, last_wp = 0, rd_run = 0, last_rd = 0;
  int rec_run = 0, last_rec = 0, done_seen = 0, viol = 0;
  logic last_lo_n = 1, last_hi_n = 1;
  logic prev_done = 0, prev_we_n = 1;

  sram_ctrl #(.CLK_NS(CLK_PERIOD)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .rd_data(rd_data), .done(done),
    .mem_addr(mem_addr), .mem_sel_n(mem_sel_n), .mem_sel(mem_sel), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_lo_n(mem_lo_n), .mem_hi_n(mem_hi_n),
    .mem_dat_o(mem_dat_o), .mem_dat_oe(mem_dat_oe), .mem_dat_i(mem_dat_i)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] init_val(input logic [18:0] a);
    return a[15:0] ^ {a[18:16], 13'h1A5A};
  endfunction

  function automatic logic [15:0] mem_rd(input logic [18:0] a);
    return mem_m.exists(a) ? mem_m[a] : init_val(a);
  endfunction

  function automatic logic [15:0] sh_rd(input logic [18:0] a);
    return sh_m.exists(a) ? sh_m[a] : init_val(a);
  endfunction

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h @%0t", rq, act, exp, $time);
    end
  endtask

  // memory model and monitor, both evaluated at the falling edge
  always @(negedge clk) begin
    logic [15:0] v, nv;
    logic sel;
    sel = !mem_sel_n && mem_sel;
    if (sel && !mem_we_n && mem_dat_oe) begin
      nv = mem_rd(mem_addr);
      if (!mem_lo_n) nv[7:0]  = mem_dat_o[7:0];
      if (!mem_hi_n) nv[15:8] = mem_dat_o[15:8];
      mem_m[mem_addr] = nv;
    end
    if (sel && mem_we_n && !mem_oe_n) begin
      v = mem_rd(mem_addr);
      mem_dat_i <= {mem_hi_n ? 8'hC3 : v[15:8], mem_lo_n ? 8'h3C : v[7:0]};
    end else begin
      mem_dat_i <= mem_dat_oe ? mem_dat_o : 16'hA5A5;
    end
    if (rst_n) begin
      if (mem_dat_oe && (!mem_oe_n || oe_run < OHZ_CYC)) viol++;   // R6
      if (!mem_we_n && !(sel)) viol++;                            // R5
      if (!mem_we_n && !mem_oe_n) viol++;                          // R4
      if (!mem_we_n && !prev_we_n && $changed(mem_addr)) viol++;   // R5
      if (done && prev_done) viol++;                               // R8
      if (mem_sel_n && (!mem_lo_n || !mem_hi_n || mem_dat_oe)) viol++; // R1
      if (!mem_we_n) we_run++;
      else if (we_run > 0) begin last_wp = we_run; we_run = 0; end
      if (!mem_oe_n) begin rd_run++; last_lo_n = mem_lo_n; last_hi_n = mem_hi_n; end
      else if (rd_run > 0) begin last_rd = rd_run; rd_run = 0; end
      if (mem_we_n && mem_dat_oe) rec_run++;
      else if (rec_run > 0) begin last_rec = rec_run; rec_run = 0; end
      if (done) done_seen++;
      oe_run = !mem_oe_n ? 0 : ((oe_run < 1000) ? oe_run + 1 : oe_run);
    end
    prev_done = done;
    prev_we_n = mem_we_n;
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  // must be called just after a falling edge (after tick)
  task automatic do_op(input bit wr, input logic [18:0] a, input logic [15:0] d,
                       input logic [1:0] be, input bit poke);
    int g, n, exp_l, d0;
    logic [15:0] e, s;
    g = oe_run;
    d0 = done_seen;
    req = 1; req_wr = wr; req_addr = a; req_wdata = d; req_be = be;
    tick();
    req = 0;
    n = 0;
    if (poke) begin
      req = 1; req_wr = 1; req_addr = 19'h00ABC; req_wdata = 16'hDEAD; req_be = 2'b11;
    end
    while (!done && n < 300) begin
      tick();
      n++;
      if (n == 1) req = 0;
    end
    if (wr) begin
      exp_l = mx(1, OHZ_CYC + 1 - g) + WP_CYC + REC_CYC;
      check(n == exp_l, "R8 write latency", n, exp_l);
      check(last_wp == WP_CYC, "R4 write pulse length", last_wp, WP_CYC);
      check(last_rec == REC_CYC, "R7 hold after pulse", last_rec, REC_CYC);
      s = sh_rd(a);
      if (be[0]) s[7:0]  = d[7:0];
      if (be[1]) s[15:8] = d[15:8];
      sh_m[a] = s;
    end else begin
      check(n == RD_CYC, "R8 read latency", n, RD_CYC);
      check(last_rd == RD_CYC, "R2 output enable length", last_rd, RD_CYC);
      check({last_hi_n, last_lo_n} == ~be, "R2 byte selects", {last_hi_n, last_lo_n}, ~be);
      e = sh_rd(a) & {{8{be[1]}}, {8{be[0]}}};
      check(rd_data == e, "R3 read data", rd_data, e);
    end
    check(done_seen - d0 == 1, poke ? "R9 busy strobe ignored" : "R8 single done", done_seen - d0, 1);
  endtask

  initial begin
    logic [18:0] pool [6];
    int unsigned sd;
    pool[0] = 19'h00000; pool[1] = 19'h7FFFF; pool[2] = 19'h00001;
    pool[3] = 19'h7FFFE; pool[4] = 19'h2AAAA; pool[5] = 19'h55555;
    sd = $urandom(32'd20250);
    repeat (3) tick();
    // R1 reset state
    check({mem_sel_n, mem_sel, mem_we_n, mem_oe_n, mem_lo_n, mem_hi_n, mem_dat_oe, done} == 8'b10111100,
          "R1 reset pins", {mem_sel_n, mem_sel, mem_we_n, mem_oe_n, mem_lo_n, mem_hi_n, mem_dat_oe, done}, 8'b10111100);
    check(rd_data == 16'h0, "R1 reset read data", rd_data, 0);
    rst_n = 1;
    repeat (4) tick();
    // directed corners
    do_op(1, 19'h00000, 16'h1234, 2'b11, 0);
    repeat (5) tick();
    do_op(1, 19'h7FFFF, 16'hBEEF, 2'b11, 0);
    do_op(0, 19'h00000, 16'h0, 2'b11, 0);
    do_op(1, 19'h7FFFF, 16'h99AA, 2'b10, 0);   // R7 upper lane only, right after a read
    do_op(0, 19'h7FFFF, 16'h0, 2'b11, 0);
    do_op(0, 19'h7FFFF, 16'h0, 2'b01, 0);      // R3 masked upper lane
    do_op(0, 19'h7FFFF, 16'h0, 2'b10, 0);      // R3 masked lower lane
    do_op(0, 19'h00ABC, 16'h0, 2'b11, 1);      // R9 strobe during a read
    do_op(0, 19'h00ABC, 16'h0, 2'b11, 0);      // R9 no write happened
    do_op(1, 19'h00001, 16'h0F0F, 2'b01, 1);   // R9 strobe during a write
    do_op(0, 19'h00ABC, 16'h0, 2'b11, 0);
    do_op(0, 19'h00001, 16'h0, 2'b11, 0);
    // random mix
    for (int i = 0; i < 120; i++) begin
      logic [18:0] a;
      a = pool[$urandom % 6];
      repeat ($urandom % 5) tick();
      do_op($urandom % 2 == 1, a, 16'($urandom), 2'($urandom), 0);
    end
    tick();
    check(viol == 0, "R4 R5 R6 R8 pin rule violations", viol, 0);
    check(mem_sel_n && !mem_sel && !done, "R1 idle after traffic", {mem_sel_n, mem_sel, done}, 3'b100);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule